// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block holds the results of instructions that an out-of-order core has issued speculatively. The issue stage reserves a slot at the tail for each instruction, in program order, and receives the slot index as a tag. Functional units later return their result, and optionally an exception flag, against that tag in any order. The buffer keeps every result private until its slot is the oldest live one. Only then is the result released to the architectural register file, one slot per cycle.

While results wait, the rename and operand stage can ask which in-flight slot will produce a given architectural register. The buffer answers with the youngest live producer of that register and, if it has already completed, with its value. After retirement the register file supplies the operand and the lookup misses.

Two events empty the whole buffer. The first is an external misspeculation flush. The second is a precise trap: when the oldest slot completed with an exception, that slot's index is reported and it and every younger slot are dropped.

Top module: `reorder_buffer`

## Requirements
- R1: A request with `alloc_valid` high, accepted while `alloc_ready` is high and in a cycle with neither flush nor trap, creates a live slot at index `alloc_idx`. After each accepted request `alloc_idx` advances by one, modulo DEPTH.
- R2: With DEPTH live slots, `alloc_ready` is low and an allocation request in that cycle changes nothing. An empty buffer and a full buffer are told apart correctly.
- R3: Completions may arrive for any live slot in any order. They record data and the exception flag but do not release the slot until it is the oldest.
- R4: When the oldest live slot has completed without exception, `commit_valid` is high in that same cycle with its register and data. At most one slot retires per cycle, in allocation order.
- R5: When the oldest live slot has completed with the exception flag, `exc_valid` is high and `exc_idx` holds its index, and `commit_valid` stays low. In the next cycle the buffer is empty, and an allocation in the trap cycle is dropped.
- R6: `lookup_hit` is high when some live slot targets `lookup_reg`. In that case `lookup_idx` names the youngest such slot, `lookup_ready` reports whether it has completed, and `lookup_data` holds its result when it has.
- R7: A cycle with `flush` high suppresses retirement and trap and drops any allocation or completion in that cycle. In the next cycle the buffer is empty and `alloc_idx` equals the index of the former oldest slot.
- R8: A completion whose index names no live slot changes no state.
- R9: After reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `commit_valid`, `exc_valid` and `lookup_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Request to reserve a slot at the tail |
| alloc_reg | input | REG_W | Destination register of the new instruction |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | IDX_W | Index the next accepted allocation receives |
| cmpl_valid | input | 1 | A functional unit returns a result |
| cmpl_idx | input | IDX_W | Slot index of the returned result |
| cmpl_data | input | DATA_W | Result value |
| cmpl_exc | input | 1 | Result raised an exception |
| lookup_reg | input | REG_W | Register whose pending producer is queried |
| lookup_hit | output | 1 | A live slot produces `lookup_reg` |
| lookup_ready | output | 1 | That producer has completed |
| lookup_data | output | DATA_W | Completed value of that producer |
| lookup_idx | output | IDX_W | Index of the youngest producer |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_reg | output | REG_W | Register written on retirement |
| commit_data | output | DATA_W | Value written on retirement |
| exc_valid | output | 1 | Precise trap on the oldest slot |
| exc_idx | output | IDX_W | Index of the trapping slot |
| flush | input | 1 | Misspeculation: drop every live slot |

## Verification
The bench fills the buffer exactly to capacity and tries one allocation more. A pointer pair without the extra wrap bit would then read as empty and either drop every slot or overwrite the oldest. Completions arrive out of order and repeat a register across several slots: a design that retires ahead of the head would release results early, and one that picks the oldest producer would hand the rename stage a stale tag. Exceptions are placed on younger slots so that they must wait for older retirements. Completions aimed at free slots, and flushes that coincide with allocation and completion, expose a design that leaks writes into dead slots or keeps entries across a discard.

// File: rtl/rob_pkg.sv
// Shared types for the reorder buffer.
// Assumes: nothing beyond a single clock domain.
package rob_pkg;

    // Condition of the oldest live slot.
    typedef enum logic [1:0] {
        HEAD_IDLE   = 2'd0,  // no live slot
        HEAD_WAIT   = 2'd1,  // oldest slot has not completed
        HEAD_RETIRE = 2'd2,  // oldest slot completed cleanly
        HEAD_TRAP   = 2'd3   // oldest slot completed with an exception
    } head_state_e;

endpackage

// File: rtl/rob_ptrs.sv
// Head/tail pointers of the circular slot array.
// Each pointer carries one wrap bit above the index, so occupancy is the
// plain difference and a full buffer differs from an empty one.
// Assumes: DEPTH is a power of two; push is never asserted when full.
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [IDX_W:0]   occupancy,
    output logic [DEPTH-1:0] live_mask
);
    logic [IDX_W:0] head_q;
    logic [IDX_W:0] tail_q;

    // Advance or collapse the pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (clear) begin
            tail_q <= head_q;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
        end
    end

    assign head_idx  = head_q[IDX_W-1:0];
    assign tail_idx  = tail_q[IDX_W-1:0];
    assign occupancy = tail_q - head_q;

    // A slot is live when its age from the head is below the occupancy.
    for (genvar i = 0; i < DEPTH; i++) begin : g_live
        logic [IDX_W-1:0] age;
        assign age          = IDX_W'(i) - head_idx;
        assign live_mask[i] = {1'b0, age} < occupancy;
    end
endmodule

// File: rtl/rob_store.sv
// Per-slot storage: destination register, result, done and exception flags.
// Allocation clears the flags; completion sets done and stores the result.
// Assumes: the caller gates completion to live slots only, and never
// allocates and completes the same slot in one cycle.
module rob_store #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_en,
    input  logic [IDX_W-1:0]              alloc_idx,
    input  logic [REG_W-1:0]              alloc_reg,
    input  logic                          cmpl_en,
    input  logic [IDX_W-1:0]              cmpl_idx,
    input  logic [DATA_W-1:0]             cmpl_data,
    input  logic                          cmpl_exc,
    output logic [DEPTH-1:0]              done_vec,
    output logic [DEPTH-1:0]              exc_vec,
    output logic [DEPTH-1:0][REG_W-1:0]   reg_vec,
    output logic [DEPTH-1:0][DATA_W-1:0]  data_vec
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Write one slot on allocation or completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done_vec[i] <= 1'b0;
                exc_vec[i]  <= 1'b0;
                reg_vec[i]  <= '0;
                data_vec[i] <= '0;
            end else if (alloc_en && alloc_idx == IDX_W'(i)) begin
                done_vec[i] <= 1'b0;
                exc_vec[i]  <= 1'b0;
                reg_vec[i]  <= alloc_reg;
            end else if (cmpl_en && cmpl_idx == IDX_W'(i)) begin
                done_vec[i] <= 1'b1;
                exc_vec[i]  <= cmpl_exc;
                data_vec[i] <= cmpl_data;
            end
        end
    end
endmodule

// File: rtl/rob_lookup.sv
// Operand lookup: finds the youngest live slot writing a register.
// Scans slots by age from the head; a later match overrides an earlier one.
// Assumes: live_mask marks exactly the slots between head and tail.
module rob_lookup #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]              head_idx,
    input  logic [DEPTH-1:0]              live_mask,
    input  logic [DEPTH-1:0][REG_W-1:0]   reg_vec,
    input  logic [DEPTH-1:0]              done_vec,
    input  logic [DEPTH-1:0][DATA_W-1:0]  data_vec,
    input  logic [REG_W-1:0]              query_reg,
    output logic                          hit,
    output logic                          ready,
    output logic [DATA_W-1:0]             data,
    output logic [IDX_W-1:0]              idx
);
    logic [DEPTH-1:0] match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        assign match[i] = live_mask[i] && (reg_vec[i] == query_reg);
    end

    // Age-ordered scan keeping the last (youngest) match.
    always_comb begin
        logic [IDX_W-1:0] slot;
        hit = 1'b0;
        idx = head_idx;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head_idx + IDX_W'(k);
            if (match[slot]) begin
                hit = 1'b1;
                idx = slot;
            end
        end
    end

    assign ready = hit && done_vec[idx];
    assign data  = data_vec[idx];
endmodule

// File: rtl/reorder_buffer.sv
// Reorder buffer top: allocates slots in program order, accepts results out
// of order, retires the oldest completed slot each cycle, raises a precise
// trap for an excepting oldest slot and empties itself on flush or trap.
// Assumes: DEPTH is a power of two; cmpl_idx refers to a tag handed out
// by alloc_idx (stale tags are ignored).
module reorder_buffer
    import rob_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [REG_W-1:0]  alloc_reg,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic [DATA_W-1:0] cmpl_data,
    input  logic              cmpl_exc,
    input  logic [REG_W-1:0]  lookup_reg,
    output logic              lookup_hit,
    output logic              lookup_ready,
    output logic [DATA_W-1:0] lookup_data,
    output logic [IDX_W-1:0]  lookup_idx,
    output logic              commit_valid,
    output logic [REG_W-1:0]  commit_reg,
    output logic [DATA_W-1:0] commit_data,
    output logic              exc_valid,
    output logic [IDX_W-1:0]  exc_idx,
    input  logic              flush
);
    logic [IDX_W-1:0]             head_idx;
    logic [IDX_W-1:0]             tail_idx;
    logic [IDX_W:0]               occupancy;
    logic [DEPTH-1:0]             live_mask;
    logic [DEPTH-1:0]             done_vec;
    logic [DEPTH-1:0]             exc_vec;
    logic [DEPTH-1:0][REG_W-1:0]  reg_vec;
    logic [DEPTH-1:0][DATA_W-1:0] data_vec;
    head_state_e                  head_state;
    logic                         discard;
    logic                         push;
    logic                         cmpl_en;

    // Classify the oldest live slot.
    always_comb begin
        if (occupancy == '0)        head_state = HEAD_IDLE;
        else if (!done_vec[head_idx]) head_state = HEAD_WAIT;
        else if (exc_vec[head_idx])   head_state = HEAD_TRAP;
        else                          head_state = HEAD_RETIRE;
    end

    assign alloc_ready  = occupancy != (IDX_W+1)'(DEPTH);
    assign alloc_idx    = tail_idx;
    assign commit_valid = (head_state == HEAD_RETIRE) && !flush;
    assign exc_valid    = (head_state == HEAD_TRAP) && !flush;
    assign commit_reg   = reg_vec[head_idx];
    assign commit_data  = data_vec[head_idx];
    assign exc_idx      = head_idx;
    assign discard      = flush || exc_valid;
    assign push         = alloc_valid && alloc_ready && !discard;
    assign cmpl_en      = cmpl_valid && live_mask[cmpl_idx] && !discard;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (commit_valid),
        .clear     (discard),
        .head_idx  (head_idx),
        .tail_idx  (tail_idx),
        .occupancy (occupancy),
        .live_mask (live_mask)
    );

    rob_store #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (push),
        .alloc_idx (tail_idx),
        .alloc_reg (alloc_reg),
        .cmpl_en   (cmpl_en),
        .cmpl_idx  (cmpl_idx),
        .cmpl_data (cmpl_data),
        .cmpl_exc  (cmpl_exc),
        .done_vec  (done_vec),
        .exc_vec   (exc_vec),
        .reg_vec   (reg_vec),
        .data_vec  (data_vec)
    );

    rob_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_lookup (
        .head_idx  (head_idx),
        .live_mask (live_mask),
        .reg_vec   (reg_vec),
        .done_vec  (done_vec),
        .data_vec  (data_vec),
        .query_reg (lookup_reg),
        .hit       (lookup_hit),
        .ready     (lookup_ready),
        .data      (lookup_data),
        .idx       (lookup_idx)
    );
endmodule

// File: rtl/reorder_buffer_chk.sv
// Property checker for reorder_buffer, attached by bind below.
// Assumes: occupancy is the top's count of live slots.
module reorder_buffer_chk #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           alloc_valid,
    input logic           alloc_ready,
    input logic           flush,
    input logic           commit_valid,
    input logic           exc_valid,
    input logic           lookup_hit,
    input logic [IDX_W:0] occupancy
);
    // R2: occupancy never passes capacity
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= (IDX_W+1)'(DEPTH));

    // R1: a clean accepted allocation grows the buffer by one
    p_alloc_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !flush && !exc_valid && !commit_valid)
        |=> occupancy == $past(occupancy) + 1'b1);

    // R4: a retirement without allocation shrinks the buffer by one
    p_retire_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !alloc_valid)
        |=> occupancy == $past(occupancy) - 1'b1);

    // R5: retirement and trap never coincide
    p_retire_trap_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_valid && exc_valid));

    // R5: a trap leaves the buffer empty
    p_trap_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> occupancy == '0);

    // R7: a flush leaves nothing to retire or look up
    p_flush_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occupancy == '0 && !lookup_hit && !commit_valid && !exc_valid));
endmodule

bind reorder_buffer reorder_buffer_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .flush        (flush),
    .commit_valid (commit_valid),
    .exc_valid    (exc_valid),
    .lookup_hit   (lookup_hit),
    .occupancy    (occupancy)
);

// File: tb/tb_reorder_buffer.sv
// Bench: queue-based reference model compared with the outputs every cycle.
module tb_reorder_buffer;
    localparam int DEPTH = 8;
    localparam int NUM_REGS = 32;
    localparam int DATA_W = 32;
    localparam int IDX_W = 3;
    localparam int REG_W = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              alloc_valid;
    logic [REG_W-1:0]  alloc_reg;
    logic              alloc_ready;
    logic [IDX_W-1:0]  alloc_idx;
    logic              cmpl_valid;
    logic [IDX_W-1:0]  cmpl_idx;
    logic [DATA_W-1:0] cmpl_data;
    logic              cmpl_exc;
    logic [REG_W-1:0]  lookup_reg;
    logic              lookup_hit;
    logic              lookup_ready;
    logic [DATA_W-1:0] lookup_data;
    logic [IDX_W-1:0]  lookup_idx;
    logic              commit_valid;
    logic [REG_W-1:0]  commit_reg;
    logic [DATA_W-1:0] commit_data;
    logic              exc_valid;
    logic [IDX_W-1:0]  exc_idx;
    logic              flush;

    reorder_buffer #(.DEPTH(DEPTH), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_reg(alloc_reg),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
        .cmpl_data(cmpl_data), .cmpl_exc(cmpl_exc),
        .lookup_reg(lookup_reg), .lookup_hit(lookup_hit),
        .lookup_ready(lookup_ready), .lookup_data(lookup_data),
        .lookup_idx(lookup_idx),
        .commit_valid(commit_valid), .commit_reg(commit_reg),
        .commit_data(commit_data),
        .exc_valid(exc_valid), .exc_idx(exc_idx),
        .flush(flush)
    );

    typedef struct {
        int          idx;
        int          rg;
        bit          done;
        bit          exc;
        logic [31:0] data;
    } slot_t;

    slot_t model_q[$];
    int    model_head;
    int    n_cmp;
    int    n_bad;
    string phase;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s actual=%0h expected=%0h",
                     req, phase, what, act, exp);
        end
    endtask

    // Compare this cycle's outputs with the model, then advance the model.
    task automatic tick();
        int  size;
        bit  full;
        int  e_aidx;
        bit  e_commit;
        bit  e_exc;
        bit  e_hit;
        int  li;
        #1;
        size     = model_q.size();
        full     = (size == DEPTH);
        e_aidx   = (model_head + size) % DEPTH;
        e_commit = (size > 0) && model_q[0].done && !model_q[0].exc && !flush;
        e_exc    = (size > 0) && model_q[0].done && model_q[0].exc && !flush;
        e_hit    = 1'b0;
        li       = 0;
        foreach (model_q[k]) if (model_q[k].rg == int'(lookup_reg)) begin
            e_hit = 1'b1;
            li    = k;
        end
        chk("R2", "alloc_ready", alloc_ready, !full);
        chk("R1", "alloc_idx", alloc_idx, e_aidx);
        chk("R4", "commit_valid", commit_valid, e_commit);
        if (e_commit) begin
            chk("R4", "commit_reg", commit_reg, model_q[0].rg);
            chk("R4", "commit_data", commit_data, model_q[0].data);
        end
        chk("R5", "exc_valid", exc_valid, e_exc);
        if (e_exc) chk("R5", "exc_idx", exc_idx, model_q[0].idx);
        chk("R6", "lookup_hit", lookup_hit, e_hit);
        if (e_hit) begin
            chk("R6", "lookup_idx", lookup_idx, model_q[li].idx);
            chk("R6", "lookup_ready", lookup_ready, model_q[li].done);
            if (model_q[li].done)
                chk("R6", "lookup_data", lookup_data, model_q[li].data);
        end
        if (flush || e_exc) begin
            model_q.delete();
        end else begin
            if (cmpl_valid) foreach (model_q[k]) if (model_q[k].idx == int'(cmpl_idx)) begin
                model_q[k].done = 1'b1;
                model_q[k].exc  = cmpl_exc;
                model_q[k].data = cmpl_data;
            end
            if (e_commit) begin
                void'(model_q.pop_front());
                model_head = (model_head + 1) % DEPTH;
            end
            if (alloc_valid && !full)
                model_q.push_back('{idx: e_aidx, rg: int'(alloc_reg),
                                    done: 1'b0, exc: 1'b0, data: '0});
        end
        @(negedge clk);
    endtask

    task automatic cyc(input bit av, input int ar, input bit cv, input int ci,
                       input int cd, input bit ce, input int lr, input bit fl);
        alloc_valid = av;
        alloc_reg   = REG_W'(ar);
        cmpl_valid  = cv;
        cmpl_idx    = IDX_W'(ci);
        cmpl_data   = DATA_W'(cd);
        cmpl_exc    = ce;
        lookup_reg  = REG_W'(lr);
        flush       = fl;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        n_cmp = 0; n_bad = 0; model_head = 0; phase = "R9 reset";
        rst_n = 1'b0;
        alloc_valid = 0; alloc_reg = '0; cmpl_valid = 0; cmpl_idx = '0;
        cmpl_data = '0; cmpl_exc = 0; lookup_reg = '0; flush = 0;
        repeat (3) @(negedge clk);
        // R9: empty after reset
        chk("R9", "alloc_ready", alloc_ready, 1);
        chk("R9", "alloc_idx", alloc_idx, 0);
        chk("R9", "commit_valid", commit_valid, 0);
        chk("R9", "exc_valid", exc_valid, 0);
        chk("R9", "lookup_hit", lookup_hit, 0);
        rst_n = 1'b1;

        // R1/R2: fill to capacity, then try one more with registers repeating
        phase = "R1 R2 fill";
        for (int i = 0; i < DEPTH; i++) cyc(1, i % 3, 0, 0, 0, 0, i % 3, 0);
        cyc(1, 7, 0, 0, 0, 0, 7, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);

        // R3/R6: out-of-order completions, youngest-producer lookups
        phase = "R3 R6 out of order";
        cyc(0, 0, 1, 5, 32'h55, 0, 2, 0);
        cyc(0, 0, 1, 2, 32'h22, 0, 2, 0);
        cyc(0, 0, 1, 3, 32'h33, 0, 0, 0);
        cyc(0, 0, 1, 1, 32'h11, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        // R4: completing the head releases the in-order run
        phase = "R4 retire";
        cyc(0, 0, 1, 0, 32'h100, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, i % 3, 0);

        // R8: completions aimed at free slots
        phase = "R8 stale";
        cyc(0, 0, 1, 0, 32'hdead, 0, 0, 0);
        cyc(0, 0, 1, 2, 32'hbeef, 0, 2, 0);
        for (int i = 0; i < 3; i++) cyc(1, 9, 0, 0, 0, 0, 9, 0);

        // R5: exception on a younger slot waits for older retirement
        phase = "R5 trap";
        cyc(1, 4, 1, 7, 32'h7, 1, 9, 0);
        cyc(1, 6, 1, 6, 32'h6, 0, 4, 0);
        cyc(0, 0, 1, 5, 32'h5, 0, 6, 0);
        cyc(0, 0, 1, 0, 32'h8, 0, 9, 0);
        cyc(1, 3, 1, 1, 32'h9, 0, 3, 0);
        for (int i = 0; i < 4; i++) cyc(1, 3, 0, 0, 0, 0, 3, 0);

        // R7: flush with simultaneous allocation and completion
        phase = "R7 flush";
        cyc(0, 0, 1, 2, 32'h77, 0, 3, 0);
        cyc(1, 5, 1, 3, 32'h78, 0, 3, 1);
        cyc(1, 5, 0, 0, 0, 0, 5, 0);
        cyc(0, 0, 1, 3, 32'h79, 0, 5, 0);
        cyc(0, 0, 0, 0, 0, 0, 5, 0);

        // Mixed traffic covering R1 to R8
        phase = "random";
        for (int n = 0; n < 4000; n++) begin
            int pick;
            int cands[$];
            bit cv;
            int ci;
            foreach (model_q[k]) if (!model_q[k].done) cands.push_back(model_q[k].idx);
            cv = ($urandom % 10) < 7;
            if (cands.size() > 0 && ($urandom % 10) < 8) begin
                pick = int'($urandom % cands.size());
                ci   = cands[pick];
            end else begin
                ci = int'($urandom % DEPTH);
            end
            cyc(($urandom % 10) < 6, int'($urandom % 8), cv, ci, int'($urandom),
                ($urandom % 20) == 0, int'($urandom % 8), ($urandom % 50) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule